// File: doc/BRIEF.md
# Seven-to-One Three-Lane Serializer

This block turns a 21-bit parallel word into serial streams. On each rising edge of a word clock it captures all 21 input bits. It then sends them as three serial data lanes of seven bits each, clocked by a bit clock that runs at seven times the word rate and is phase-locked to it. The bit clock comes from outside the block. A fourth lane repeats a fixed seven-bit pattern once per word period, so that a receiver can find where each word starts.

The captured word crosses into the bit-clock domain through a toggle handshake. A whole word is loaded into the lane shift registers at one frame boundary, so a frame never carries bits from two different words. An active-low power-down input gates all four lanes off. An output-enable signal stands in for the high-impedance state of the drivers. When power-down is released, the output-enable rises first. All lanes then stay low for a hold-off of `LOCK_WORDS` word periods, which models the settling time of a clock synthesizer, and only then does the block start to toggle them.

Top module: `lane_serializer7`

## Requirements
- R1: While `rstN` is low, `outEn` is 0 and all four lane outputs are 0.
- R2: Once `pwrDownN` has been low at two consecutive rising edges of `bitClk`, `outEn` is 0 and `laneData` and `laneClk` are all 0.
- R3: If `pwrDownN` is raised between two `bitClk` rising edges, `outEn` reads 0 after the first following edge and 1 after the second. All lanes stay 0 until edge 2+7·`LOCK_WORDS`, and `laneClk` first reads 1 after that edge.
- R4: `laneData[0]` carries word bits 6 down to 0, `laneData[1]` carries bits 13 down to 7, and `laneData[2]` carries bits 20 down to 14. Within a lane the highest-numbered bit goes first and the lowest-numbered bit goes last.
- R5: In every frame, `laneClk` sends 1,1,0,0,0,1,1 (the pattern 7'b1100011, MSB first), and this is aligned with the first data bit of the frame.
- R6: Successive frames carry successive words sampled on rising edges of `wordClk`. Each word is sent whole, and none is skipped or repeated.
- R7: Power-down during transmission, followed by a new release, restarts the hold-off and the frame alignment of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Serial bit clock, seven times the word rate, phase-locked to `wordClk` |
| wordClk | input | 1 | Word clock; each rising edge samples `wordIn` |
| rstN | input | 1 | Active-low synchronous reset for both domains |
| pwrDownN | input | 1 | Active-low power-down; synchronized into the bit domain |
| wordIn | input | 21 | Parallel input word |
| laneData | output | 3 | Serial data lanes, one bit per lane |
| laneClk | output | 1 | Serial clock-pattern lane |
| outEn | output | 1 | Driver enable; 0 models the high-impedance state |

## Verification
The bench overrides `LOCK_WORDS` to 3 and keeps three lanes of seven bits. With this value the exact edge at which the hold-off ends is reached twice in a short run: once after the first release and once after a power-down in the middle of the stream. The bench rebuilds each word from the frames aligned on the clock pattern. Random words and directed words are then matched against the words it sampled. The directed words are all ones, all zeros, alternating bits, and single bits at the edges of each lane group, so a bad lane mapping, bit order, frame boundary or skipped word shows up at the ports.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

  // Strobes from the control FSM to the datapath, all in the bit domain.
  typedef struct packed {
    logic holdLoad;   // a new captured word has crossed; refresh holding reg
    logic frameLoad;  // last bit of frame; reload shifters next edge
    logic active;     // hold-off finished and powered up; lanes may toggle
  } strobe_t;

endpackage

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
  import serlink_pkg::*;
#(
  parameter int BITS       = 7,
  parameter int LOCK_WORDS = 64,
  localparam int PH_W      = $clog2(BITS),
  localparam int CNT_W     = $clog2(LOCK_WORDS + 1)
) (
  input  logic            bitClk,
  input  logic            rstN,
  input  logic            pwrDownN,
  input  logic            wordTgl,
  output strobe_t         strobes,
  output logic            outEn,
  output logic [PH_W-1:0] phase
);

  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(BITS - 1);
  localparam logic [CNT_W-1:0] LOCK_END = CNT_W'(LOCK_WORDS);

  logic             pdMeta, pdSync;
  logic             tglMeta, tglSync, tglSeen;
  logic [CNT_W-1:0] lockCnt;

  // Synchronizers for power-down and the word-domain handshake toggle.
  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      pdMeta  <= 1'b0;
      pdSync  <= 1'b0;
      tglMeta <= 1'b0;
      tglSync <= 1'b0;
      tglSeen <= 1'b0;
    end else begin
      pdMeta  <= pwrDownN;
      pdSync  <= pdMeta;
      tglMeta <= wordTgl;
      tglSync <= tglMeta;
      tglSeen <= tglSync;
    end
  end

  // Bit phase within the frame and the hold-off counter in frames.
  always_ff @(posedge bitClk) begin
    if (!rstN || !pdSync) begin
      phase   <= '0;
      lockCnt <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
      if (lockCnt != LOCK_END) lockCnt <= lockCnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobes.holdLoad  = tglSync ^ tglSeen;
    strobes.frameLoad = pdSync && (phase == LAST_PH);
    strobes.active    = pdSync && (lockCnt == LOCK_END);
    outEn             = pdSync;
  end

endmodule

// File: rtl/serlink_datapath.sv
module serlink_datapath
  import serlink_pkg::*;
#(
  parameter int LANES = 3,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int WORD_W = LANES * BITS
) (
  input  logic              wordClk,
  input  logic              bitClk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  strobe_t           strobes,
  output logic              wordTgl,
  output logic [LANES-1:0]  laneData,
  output logic              laneClk
);

  logic [WORD_W-1:0] capWord;
  logic [WORD_W-1:0] holdWord;
  logic [BITS-1:0]   clkShift;

  // Word domain: sample and flip the handshake toggle.
  always_ff @(posedge wordClk) begin
    if (!rstN) begin
      capWord <= '0;
      wordTgl <= 1'b0;
    end else begin
      capWord <= wordIn;
      wordTgl <= ~wordTgl;
    end
  end

  // Bit domain: capWord is static for several bit clocks around holdLoad.
  always_ff @(posedge bitClk) begin
    if (!rstN)                 holdWord <= '0;
    else if (strobes.holdLoad) holdWord <= capWord;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BITS-1:0] shiftQ;
    always_ff @(posedge bitClk) begin
      if (!rstN)                  shiftQ <= '0;
      else if (strobes.frameLoad) shiftQ <= holdWord[g*BITS +: BITS];
      else                        shiftQ <= {shiftQ[BITS-2:0], 1'b0};
    end
    assign laneData[g] = strobes.active & shiftQ[BITS-1];
  end

  always_ff @(posedge bitClk) begin
    if (!rstN)                  clkShift <= '0;
    else if (strobes.frameLoad) clkShift <= CLK_PATTERN;
    else                        clkShift <= {clkShift[BITS-2:0], 1'b0};
  end

  assign laneClk = strobes.active & clkShift[BITS-1];

endmodule

// File: rtl/lane_serializer7.sv
module lane_serializer7
  import serlink_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int BITS       = 7,
  parameter int LOCK_WORDS = 64,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int WORD_W    = LANES * BITS,
  localparam int PH_W      = $clog2(BITS)
) (
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              rstN,
  input  logic              pwrDownN,
  input  logic [WORD_W-1:0] wordIn,
  output logic [LANES-1:0]  laneData,
  output logic              laneClk,
  output logic              outEn
);

  strobe_t         strobes;
  logic            wordTgl;
  logic [PH_W-1:0] phase;

  serlink_ctrl #(.BITS(BITS), .LOCK_WORDS(LOCK_WORDS)) u_ctrl (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .pwrDownN(pwrDownN),
    .wordTgl (wordTgl),
    .strobes (strobes),
    .outEn   (outEn),
    .phase   (phase)
  );

  serlink_datapath #(.LANES(LANES), .BITS(BITS), .CLK_PATTERN(CLK_PATTERN)) u_dp (
    .wordClk (wordClk),
    .bitClk  (bitClk),
    .rstN    (rstN),
    .wordIn  (wordIn),
    .strobes (strobes),
    .wordTgl (wordTgl),
    .laneData(laneData),
    .laneClk (laneClk)
  );

endmodule

// File: rtl/serlink_checker.sv
module serlink_checker #(
  parameter int LANES = 3,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int PH_W = $clog2(BITS)
) (
  input logic             bitClk,
  input logic             rstN,
  input logic             pwrDownN,
  input logic             outEn,
  input logic [LANES-1:0] laneData,
  input logic             laneClk,
  input logic [PH_W-1:0]  phase,
  input logic             active
);

  logic [1:0] sinceRst;
  always_ff @(posedge bitClk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  // R2: two sampled low power-down values force the drivers off.
  assert_pd_tristate_R2: assert property (@(posedge bitClk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(pwrDownN) && !$past(pwrDownN, 2)) |-> !outEn);

  // R2: lanes are quiet whenever drivers are off.
  assert_quiet_when_off_R2: assert property (@(posedge bitClk) disable iff (!rstN)
    !outEn |-> (laneData == '0 && !laneClk));

  // R3: enabling the drivers starts with idle lanes.
  assert_holdoff_idle_R3: assert property (@(posedge bitClk) disable iff (!rstN)
    (sinceRst != 2'd0 && $rose(outEn)) |-> (laneData == '0 && !laneClk));

  // R5: clock lane follows the fixed pattern against the control phase.
  assert_clock_pattern_R5: assert property (@(posedge bitClk) disable iff (!rstN)
    active |-> (laneClk == CLK_PATTERN[BITS-1-int'(phase)]));

endmodule

bind lane_serializer7 serlink_checker #(
  .LANES(LANES), .BITS(BITS), .CLK_PATTERN(CLK_PATTERN)
) u_checker (
  .bitClk  (bitClk),
  .rstN    (rstN),
  .pwrDownN(pwrDownN),
  .outEn   (outEn),
  .laneData(laneData),
  .laneClk (laneClk),
  .phase   (phase),
  .active  (strobes.active)
);

// File: tb/test_lane_serializer7.sv
module test_lane_serializer7;

  localparam int BIT_PERIOD = 10;
  localparam int LOCK_W     = 3;
  localparam logic [6:0] PATTERN = 7'b1100011;

  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrDownN = 1'b1;
  logic [20:0] wordIn = '0;
  logic [2:0]  laneData;
  logic        laneClk;
  logic        outEn;

  int checks = 0;
  int fails  = 0;
  logic [20:0] sent [0:4095];
  int nSent = 0;
  int wordIdx = 0;

  lane_serializer7 #(.LOCK_WORDS(LOCK_W)) i_lane_serializer7 (
    .bitClk(bitClk), .wordClk(wordClk), .rstN(rstN), .pwrDownN(pwrDownN),
    .wordIn(wordIn), .laneData(laneData), .laneClk(laneClk), .outEn(outEn)
  );

  always #(BIT_PERIOD/2) bitClk = ~bitClk;
  initial begin
    #2;
    forever #(7*BIT_PERIOD/2) wordClk = ~wordClk;
  end

  function automatic logic [20:0] makeWord(int idx);
    case (idx)
      30: return 21'h1FFFFF;
      31: return 21'h000000;
      32: return 21'h155555;
      33: return 21'h0AAAAA;
      34: return 21'h000001;
      35: return 21'h000040;
      36: return 21'h000080;
      37: return 21'h100000;
      default: return 21'($urandom());
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Word driver: record what each rising wordClk edge samples.
  initial begin
    void'($urandom(32'd4711));
    forever begin
      @(posedge wordClk);
      if (rstN && nSent < 4096) begin
        sent[nSent] = wordIn;
        nSent++;
      end
      #3;
      wordIn = makeWord(wordIdx);
      wordIdx++;
    end
  end

  // Release power-down, check the hold-off, then decode frames (R3 R4 R5 R6).
  task automatic runSegment(input int frames, input string tag);
    logic busy;
    int   expIdx;
    pwrDownN = 1'b1;
    @(negedge bitClk);
    check(outEn == 1'b0, {"R3 outEn after edge 1 ", tag}, 32'(outEn), 32'd0);
    @(negedge bitClk);
    check(outEn == 1'b1, {"R3 outEn after edge 2 ", tag}, 32'(outEn), 32'd1);
    busy = (laneData != 3'b0) || laneClk;
    for (int e = 3; e < 2 + 7*LOCK_W; e++) begin
      @(negedge bitClk);
      if (laneData != 3'b0 || laneClk || !outEn) busy = 1'b1;
    end
    check(!busy, {"R3 lanes idle during hold-off ", tag}, 32'(busy), 32'd0);
    @(negedge bitClk);
    check(laneClk == 1'b1, {"R3 clock lane starts at edge 2+7L ", tag},
          32'(laneClk), 32'd1);
    expIdx = -1;
    for (int f = 0; f < frames; f++) begin
      logic [6:0] l0, l1, l2, ck;
      logic [20:0] got;
      l0 = '0; l1 = '0; l2 = '0; ck = '0;
      for (int b = 0; b < 7; b++) begin
        if (!(f == 0 && b == 0)) @(negedge bitClk);
        l0 = {l0[5:0], laneData[0]};
        l1 = {l1[5:0], laneData[1]};
        l2 = {l2[5:0], laneData[2]};
        ck = {ck[5:0], laneClk};
      end
      got = {l2, l1, l0};
      check(ck == PATTERN, {"R5 clock lane pattern ", tag}, 32'(ck), 32'(PATTERN));
      if (expIdx < 0) begin
        for (int j = nSent - 1; j >= 0 && j >= nSent - 4; j--)
          if (expIdx < 0 && sent[j] == got) expIdx = j;
        check(expIdx >= 0, {"R4 R6 first frame matches a recent word ", tag},
              32'(got), 32'(sent[nSent-1]));
        expIdx++;
      end else begin
        check(got == sent[expIdx], {"R4 R6 frame carries next word ", tag},
              32'(got), 32'(sent[expIdx]));
        expIdx++;
      end
    end
  endtask

  initial begin
    // R1: reset holds outputs off even with power-down released.
    repeat (3) @(negedge bitClk);
    check(outEn == 1'b0 && laneData == 3'b0 && laneClk == 1'b0, "R1 reset state",
          {28'd0, outEn, laneData}, 32'd0);
    pwrDownN = 1'b0;
    @(negedge bitClk);
    rstN = 1'b1;
    repeat (10) @(negedge bitClk);
    check(outEn == 1'b0 && laneData == 3'b0 && laneClk == 1'b0, "R2 held in power-down",
          {28'd0, outEn, laneData}, 32'd0);

    runSegment(60, "first");

    // R2 R7: power-down in the middle of the stream, then restart.
    pwrDownN = 1'b0;
    @(negedge bitClk);
    @(negedge bitClk);
    check(outEn == 1'b0 && laneData == 3'b0 && laneClk == 1'b0,
          "R2 power-down mid-stream", {28'd0, outEn, laneData}, 32'd0);
    repeat (20) @(negedge bitClk);
    check(outEn == 1'b0, "R2 stays off", 32'(outEn), 32'd0);
    runSegment(40, "R7 restart");

    finishRun();
  end

  initial begin
    #(BIT_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

endmodule